// File: doc/BRIEF.md
# Power-Stage Protection Supervisor

This block decides whether a motor bridge may drive its outputs. It collects digital event flags from the analog side: two supply comparators that form a hysteresis pair, an overcurrent/short-circuit detector, a sense-input overrange detector and an over-temperature indication. It also takes two threshold readings of the shared enable/fault pin and a low-power request. From these it produces a bridge enable, a request to pull the shared pin low, and a one-cycle home request for the step sequencer.

Every incoming flag is asynchronous and passes through a two-stage synchroniser. The supply state uses separate turn-on and turn-off flags, so a supply level between the two thresholds keeps whatever state it already had. An overcurrent or overrange event latches. The latch holds the pin pull-down until the pin itself is seen below its release level. The external RC network then charges the pin back above its logic-high level, and only at that point does the bridge run again. Over-temperature does not latch. Leaving the low-power state returns every piece of state to its power-up value and asks the sequencer to go home.

Top module: `pstage_guard`

## Requirements
- R1: During and after reset, before any supply flag is seen, `bridge_en_o` is 0, `pin_pull_o` is 1 and `seq_home_o` is 0.
- R2: After `sup_on_i` is seen high, with no other fault and `pin_hi_i` high, `pin_pull_o` drops to 0 and `bridge_en_o` rises to 1.
- R3: `sup_off_i` high clears the supply state: `bridge_en_o` goes to 0 and `pin_pull_o` goes to 1. When both supply flags are low, the supply state keeps its last value, whether that value is good or bad.
- R4: `ocp_i` high latches a fault: `bridge_en_o` goes to 0 and `pin_pull_o` goes to 1.
- R5: A latched fault stays set after `ocp_i` drops and after `pin_hi_i` drops, for as long as `pin_lo_i` has not been seen high.
- R6: `pin_lo_i` high while the fault is latched clears the latch and releases `pin_pull_o`. `bridge_en_o` returns only once `pin_hi_i` is high again.
- R7: `bridge_en_o` is 1 only while `pin_hi_i` is seen high. A low pin disables the bridge without asserting `pin_pull_o`.
- R8: `sense_ovr_i` high latches a fault exactly as `ocp_i` does.
- R9: `otp_i` high forces `bridge_en_o` to 0 and `pin_pull_o` to 1 for as long as it is high. Both outputs recover when it drops, with no pin release needed.
- R10: While `stby_i` is high, `bridge_en_o` is 0. When `stby_i` falls, `seq_home_o` is 1 for exactly one cycle, and the supply state and fault latch are back at their power-up values, so `pin_pull_o` stays 1 until `sup_on_i` is seen again.
- R11: Each input reaches the outputs through exactly `SYNC_STAGES` (default 2) flip-flops. A change in `pin_hi_i` just before an edge shows on `bridge_en_o` after the second edge and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_on_i | input | 1 | Supply above turn-on threshold (async) |
| sup_off_i | input | 1 | Supply below turn-off threshold (async) |
| ocp_i | input | 1 | Overcurrent or short-circuit detected (async) |
| sense_ovr_i | input | 1 | Sense input out of range (async) |
| otp_i | input | 1 | Over-temperature flag, hysteresis applied outside (async) |
| pin_hi_i | input | 1 | Shared enable/fault pin above logic-high level (async) |
| pin_lo_i | input | 1 | Shared enable/fault pin below release level (async) |
| stby_i | input | 1 | Low-power request (async) |
| bridge_en_o | output | 1 | Power bridge enable |
| pin_pull_o | output | 1 | Request to pull the shared pin low |
| seq_home_o | output | 1 | One-cycle sequencer home request |

## Verification
The supply flags are driven as turn-on pulses, turn-off pulses and long gaps with neither flag set. The gaps show whether hysteresis holds the state or the block simply follows the last flag. The fault scenarios drop the overcurrent flag and the pin-high reading well before the release reading arrives. This separates a true latch-until-release from a level-following fault and from a latch that clears when the pin merely goes low. Over-temperature is released without any release reading, to show that it does not latch. A single-cycle timing probe on the pin-high input pins the synchroniser depth to exactly two edges. The standby exit is sampled cycle by cycle to confirm that the home request lasts one cycle and that the supply state was reset.

// File: rtl/pstage_guard_pkg.sv
package pstage_guard_pkg;
  // Synchronised view of all asynchronous inputs.
  typedef struct packed {
    logic sup_on;
    logic sup_off;
    logic ocp;
    logic sense_ovr;
    logic otp;
    logic pin_hi;
    logic pin_lo;
    logic stby;
  } guard_flags_t;

  localparam int unsigned FLAG_W = $bits(guard_flags_t);
endpackage

// File: rtl/pstage_guard_sync.sv
module pstage_guard_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pstage_guard_supply.sv
module pstage_guard_supply (
  input  logic clk,
  input  logic rst_n,
  input  logic above_on,
  input  logic below_off,
  input  logic hold_reset,
  output logic supply_ok
);
  logic ok_d, ok_q;

  // Turn-off wins over turn-on; no flag keeps the state (hysteresis band).
  always_comb begin
    ok_d = ok_q;
    if (hold_reset)     ok_d = 1'b0;
    else if (below_off) ok_d = 1'b0;
    else if (above_on)  ok_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b0;
    else        ok_q <= ok_d;
  end

  assign supply_ok = ok_q;
endmodule

// File: rtl/pstage_guard_latch.sv
module pstage_guard_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic release_seen,
  input  logic hold_reset,
  output logic latched
);
  logic lat_d, lat_q;

  // A new trip wins over a release in the same cycle.
  always_comb begin
    lat_d = lat_q;
    if (hold_reset)                lat_d = 1'b0;
    else if (trip)                 lat_d = 1'b1;
    else if (lat_q && release_seen) lat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= 1'b0;
    else        lat_q <= lat_d;
  end

  assign latched = lat_q;
endmodule

// File: rtl/pstage_guard.sv
module pstage_guard
  import pstage_guard_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_on_i,
  input  logic sup_off_i,
  input  logic ocp_i,
  input  logic sense_ovr_i,
  input  logic otp_i,
  input  logic pin_hi_i,
  input  logic pin_lo_i,
  input  logic stby_i,
  output logic bridge_en_o,
  output logic pin_pull_o,
  output logic seq_home_o
);
  guard_flags_t flags_raw, flags_s;
  logic [FLAG_W-1:0] flags_vec;
  logic supply_ok, fault_latched;
  logic stby_d, stby_q;

  assign flags_raw = '{sup_on: sup_on_i, sup_off: sup_off_i, ocp: ocp_i,
                       sense_ovr: sense_ovr_i, otp: otp_i, pin_hi: pin_hi_i,
                       pin_lo: pin_lo_i, stby: stby_i};

  pstage_guard_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (flags_raw),
    .q_o  (flags_vec)
  );
  assign flags_s = guard_flags_t'(flags_vec);

  pstage_guard_supply u_supply (
    .clk       (clk),
    .rst_n     (rst_n),
    .above_on  (flags_s.sup_on),
    .below_off (flags_s.sup_off),
    .hold_reset(flags_s.stby),
    .supply_ok (supply_ok)
  );

  pstage_guard_latch u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .trip        (flags_s.ocp | flags_s.sense_ovr),
    .release_seen(flags_s.pin_lo),
    .hold_reset  (flags_s.stby),
    .latched     (fault_latched)
  );

  // Standby edge tracker for the home request.
  always_comb stby_d = flags_s.stby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stby_q <= 1'b0;
    else        stby_q <= stby_d;
  end

  assign pin_pull_o  = !supply_ok || fault_latched || flags_s.otp;
  assign bridge_en_o = supply_ok && !fault_latched && !flags_s.otp &&
                       flags_s.pin_hi && !flags_s.stby;
  assign seq_home_o  = stby_q && !flags_s.stby;
endmodule

// File: rtl/pstage_guard_chk.sv
module pstage_guard_chk
  import pstage_guard_pkg::*;
(
  input logic         clk,
  input logic         rst_n,
  input guard_flags_t flags_s,
  input logic         supply_ok,
  input logic         fault_latched,
  input logic         bridge_en_o,
  input logic         pin_pull_o,
  input logic         seq_home_o
);
  assert_en_needs_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_en_o |-> (flags_s.pin_hi && !pin_pull_o));

  assert_off_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flags_s.sup_off |=> !supply_ok);

  assert_trip_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_s.ocp || flags_s.sense_ovr) && !flags_s.stby) |=> fault_latched);

  assert_latch_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && !flags_s.pin_lo && !flags_s.stby) |=> fault_latched);

  assert_stby_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flags_s.stby |-> !bridge_en_o);

  assert_home_in_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_home_o |-> (pin_pull_o && !supply_ok && !fault_latched));

  assert_home_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_home_o |=> !seq_home_o);
endmodule

bind pstage_guard pstage_guard_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flags_s      (flags_s),
  .supply_ok    (supply_ok),
  .fault_latched(fault_latched),
  .bridge_en_o  (bridge_en_o),
  .pin_pull_o   (pin_pull_o),
  .seq_home_o   (seq_home_o)
);

// File: tb/pstage_guard_test.sv
module pstage_guard_test;
  logic clk = 1'b0;
  logic rst_n;
  logic sup_on, sup_off, ocp, sense_ovr, otp, pin_hi, pin_lo, stby;
  logic bridge_en, pin_pull, seq_home;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pstage_guard uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sup_on_i   (sup_on),
    .sup_off_i  (sup_off),
    .ocp_i      (ocp),
    .sense_ovr_i(sense_ovr),
    .otp_i      (otp),
    .pin_hi_i   (pin_hi),
    .pin_lo_i   (pin_lo),
    .stby_i     (stby),
    .bridge_en_o(bridge_en),
    .pin_pull_o (pin_pull),
    .seq_home_o (seq_home)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic outs(input string req, input logic en, input logic pd, input logic hm);
    check(req, "bridge_en", bridge_en, en);
    check(req, "pin_pull", pin_pull, pd);
    check(req, "seq_home", seq_home, hm);
  endtask

  task automatic power_on();
    sup_on = 1'b1; tick(1); sup_on = 1'b0; tick(4);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    {sup_on, sup_off, ocp, sense_ovr, otp, pin_lo, stby} = '0;
    pin_hi = 1'b1;
    tick(3);
    outs("R1", 1'b0, 1'b1, 1'b0);
    rst_n = 1'b1;
    tick(5);
    outs("R1", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_supply();
    power_on();
    outs("R2", 1'b1, 1'b0, 1'b0);
    tick(8);  // hysteresis band: no flag, state kept good
    outs("R3", 1'b1, 1'b0, 1'b0);
    sup_off = 1'b1; tick(4);
    outs("R3", 1'b0, 1'b1, 1'b0);
    sup_off = 1'b0; tick(8);  // band again: state kept bad
    outs("R3", 1'b0, 1'b1, 1'b0);
    power_on();
    outs("R2", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_sync_pin();
    pin_hi = 1'b0;
    tick(1);
    check("R11", "enable after one edge", bridge_en, 1'b1);
    tick(1);
    check("R11", "enable after two edges", bridge_en, 1'b0);
    check("R7", "no pull on low pin", pin_pull, 1'b0);
    pin_hi = 1'b1;
    tick(4);
    check("R7", "enable with pin high", bridge_en, 1'b1);
  endtask

  task automatic t_trip(input string req, input bit use_ovr);
    if (use_ovr) sense_ovr = 1'b1; else ocp = 1'b1;
    tick(4);
    outs(req, 1'b0, 1'b1, 1'b0);
    ocp = 1'b0; sense_ovr = 1'b0; pin_hi = 1'b0;
    tick(12);
    outs("R5", 1'b0, 1'b1, 1'b0);
    pin_lo = 1'b1; tick(4);
    outs("R6", 1'b0, 1'b0, 1'b0);
    pin_lo = 1'b0; tick(4);
    outs("R6", 1'b0, 1'b0, 1'b0);
    pin_hi = 1'b1; tick(4);
    outs("R6", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_otp();
    otp = 1'b1; tick(4);
    outs("R9", 1'b0, 1'b1, 1'b0);
    otp = 1'b0; tick(4);
    outs("R9", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_standby();
    stby = 1'b1; tick(4);
    check("R10", "enable in standby", bridge_en, 1'b0);
    check("R10", "home in standby", seq_home, 1'b0);
    tick(4);
    stby = 1'b0;
    tick(1);
    check("R10", "home before sync", seq_home, 1'b0);
    tick(1);
    check("R10", "home pulse", seq_home, 1'b1);
    tick(1);
    check("R10", "home pulse width", seq_home, 1'b0);
    tick(6);
    outs("R10", 1'b0, 1'b1, 1'b0);
    power_on();
    outs("R10", 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_supply();
    t_sync_pin();
    t_trip("R4", 1'b0);
    t_trip("R8", 1'b1);
    t_otp();
    t_standby();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule